// File: doc/BRIEF.md
# DMA Request Source Selector

This block sits in front of one DMA channel and decides which event starts a transfer. Software writes an 8-bit source-select register that carries a 4-bit cause code and a bank bit. The bank bit chooses between a basic map (timer channels, serial port transmit and receive events, a falling edge on an external interrupt pin, a software trigger) and an extended map (a clocked serial port event, either edge of the external pin). When the chosen source fires, a pending-request flag is set and offered to the transfer engine.

The pending flag is sticky. The transfer engine clears it with an acknowledge, and software can clear it by writing 0. Writing 1 to it changes nothing. The external pin passes through a two-flop synchroniser, and edge detection runs ahead of the source selector. Switching the selection therefore cannot turn a steady level on the pin into a request. Peripheral events arrive as one-cycle pulses.

Register bus: `regAddr` 0 is the source-select register, and `regAddr` 1 is the pending register, which holds the flag in bit 0. Reads are combinational.

Top module: `dma_trig_sel`

## Requirements
- R1: After reset, `dmaReq` is 0 and the source-select register reads 00h.
- R2: In the source-select register, bits 5 and 4 ignore writes and always read 0, and bit 7 always reads 0. Bit 6 is the bank bit and bits 3..0 are the cause code, and both read back as written.
- R3: A write to the source-select register that has bit 7 = 1, bit 6 = 0 and cause code 0001 sets the pending flag at that write's clock edge. Bit 7 set with any other bank or code raises no request.
- R4: In the basic bank, codes 0010, 0011, 0100 and 0101 select `periphEvt[0]`..`periphEvt[3]` (timer channels 0 to 3). A pulse on a line that is not selected has no effect.
- R5: In the basic bank, the following codes select serial events: 1010 selects `periphEvt[4]` (port 0 transmit), 1011 selects `periphEvt[5]` (port 0 receive), 1100 selects `periphEvt[6]` (port 2 transmit), 1101 selects `periphEvt[7]` (port 2 receive) and 1111 selects `periphEvt[8]` (port 1 receive).
- R6: In the basic bank, code 0000 makes each falling edge of `extPin` set the pending flag on the third rising clock edge after the pin changes. A rising edge or a steady level raises no request, and each edge produces exactly one request.
- R7: In the extended bank, code 0101 selects `periphEvt[9]` (clocked serial port 3). Code 0111 makes both pin edges raise a request, with the same latency as R6.
- R8: Codes without an assigned source never raise a request. This covers basic 0110–1001 and 1110, and extended codes other than 0101 and 0111.
- R9: The pending flag stays set until it is cleared. Writing 0 to bit 0 of the pending register clears it. Writing 1 leaves it unchanged. Reading that register returns the flag in bit 0.
- R10: `xferAck` clears the pending flag on the next edge. If a cause fires in the same cycle, the flag stays set.
- R11: Changing the bank or cause code while `extPin` is at a steady level raises no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 = source select, 1 = pending |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of addressed register |
| periphEvt | input | 10 | One-cycle peripheral event pulses |
| extPin | input | 1 | Asynchronous external interrupt pin |
| xferAck | input | 1 | Transfer engine acknowledge |
| dmaReq | output | 1 | Pending request to the transfer engine |

## Verification
The assertions take two things for granted. First, peripheral events are single-cycle pulses. Second, `extPin` is at its idle-high level while reset is asserted, because the synchroniser resets to high and a pin held low through reset would look like a falling edge. The stimulus therefore drives the pin high before reset is released. It raises each `periphEvt` line for exactly one cycle and holds the pin long enough between edges for the synchroniser to settle. All inputs change on the falling clock edge, so no setup timing is tested.

// File: rtl/dma_trig_pkg.sv
package dma_trig_pkg;
  localparam int CODE_W  = 4;
  localparam int REG_W   = 8;
  localparam int NUM_EVT = 10;
  localparam int BANK_BIT = 6;
  localparam int SWREQ_BIT = 7;

  localparam logic [CODE_W-1:0] CODE_PIN_FALL = 4'b0000;
  localparam logic [CODE_W-1:0] CODE_SOFT     = 4'b0001;
  localparam logic [CODE_W-1:0] CODE_TMR0     = 4'b0010;
  localparam logic [CODE_W-1:0] CODE_TMR1     = 4'b0011;
  localparam logic [CODE_W-1:0] CODE_TMR2     = 4'b0100;
  localparam logic [CODE_W-1:0] CODE_TMR3     = 4'b0101;
  localparam logic [CODE_W-1:0] CODE_SER0_TX  = 4'b1010;
  localparam logic [CODE_W-1:0] CODE_SER0_RX  = 4'b1011;
  localparam logic [CODE_W-1:0] CODE_SER2_TX  = 4'b1100;
  localparam logic [CODE_W-1:0] CODE_SER2_RX  = 4'b1101;
  localparam logic [CODE_W-1:0] CODE_SER1_RX  = 4'b1111;
  localparam logic [CODE_W-1:0] XCODE_SER3    = 4'b0101;
  localparam logic [CODE_W-1:0] XCODE_PIN_ANY = 4'b0111;

  localparam int EV_SER0_TX = 4;
  localparam int EV_SER0_RX = 5;
  localparam int EV_SER2_TX = 6;
  localparam int EV_SER2_RX = 7;
  localparam int EV_SER1_RX = 8;
  localparam int EV_SER3    = 9;

  typedef struct packed {
    logic selLoad;
    logic swTrig;
    logic pendClr;
  } trigStrobe_t;
endpackage

// File: rtl/dma_trig_datapath.sv
module dma_trig_datapath
  import dma_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  trigStrobe_t         strobe,
  input  logic [REG_W-1:0]    wrData,
  input  logic [NUM_EVT-1:0]  periphEvt,
  input  logic                extPin,
  output logic [CODE_W-1:0]   selCode,
  output logic                selBank,
  output logic                causeFire
);
  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] pinPipe;
  logic pinNow, pinOld, pinFall, pinRise;
  logic hwFire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selCode <= '0;
      selBank <= 1'b0;
    end else if (strobe.selLoad) begin
      selCode <= wrData[CODE_W-1:0];
      selBank <= wrData[BANK_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pinPipe[0] <= 1'b1;
    else        pinPipe[0] <= extPin;
  end

  for (genvar s = 1; s < PIPE_W; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pinPipe[s] <= 1'b1;
      else        pinPipe[s] <= pinPipe[s-1];
    end
  end

  assign pinNow  = pinPipe[SYNC_STAGES-1];
  assign pinOld  = pinPipe[SYNC_STAGES];
  assign pinFall = pinOld & ~pinNow;
  assign pinRise = ~pinOld & pinNow;

  always_comb begin
    hwFire = 1'b0;
    if (!selBank) begin
      case (selCode)
        CODE_PIN_FALL: hwFire = pinFall;
        CODE_TMR0:     hwFire = periphEvt[0];
        CODE_TMR1:     hwFire = periphEvt[1];
        CODE_TMR2:     hwFire = periphEvt[2];
        CODE_TMR3:     hwFire = periphEvt[3];
        CODE_SER0_TX:  hwFire = periphEvt[EV_SER0_TX];
        CODE_SER0_RX:  hwFire = periphEvt[EV_SER0_RX];
        CODE_SER2_TX:  hwFire = periphEvt[EV_SER2_TX];
        CODE_SER2_RX:  hwFire = periphEvt[EV_SER2_RX];
        CODE_SER1_RX:  hwFire = periphEvt[EV_SER1_RX];
        default:       hwFire = 1'b0;
      endcase
    end else begin
      case (selCode)
        XCODE_SER3:    hwFire = periphEvt[EV_SER3];
        XCODE_PIN_ANY: hwFire = pinFall | pinRise;
        default:       hwFire = 1'b0;
      endcase
    end
  end

  assign causeFire = hwFire | strobe.swTrig;
endmodule

// File: rtl/dma_trig_ctrl.sv
module dma_trig_ctrl
  import dma_trig_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             regWrEn,
  input  logic             regAddr,
  input  logic [REG_W-1:0] regWrData,
  input  logic             causeFire,
  input  logic             xferAck,
  output trigStrobe_t      strobe,
  output logic             pending
);
  logic selWr, pendWr;

  assign selWr  = regWrEn & ~regAddr;
  assign pendWr = regWrEn & regAddr;

  always_comb begin
    strobe.selLoad = selWr;
    strobe.swTrig  = selWr & regWrData[SWREQ_BIT] & ~regWrData[BANK_BIT]
                     & (regWrData[CODE_W-1:0] == CODE_SOFT);
    strobe.pendClr = pendWr & ~regWrData[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          pending <= 1'b0;
    else if (causeFire)                  pending <= 1'b1;
    else if (strobe.pendClr || xferAck)  pending <= 1'b0;
  end
endmodule

// File: rtl/dma_trig_sel.sv
module dma_trig_sel
  import dma_trig_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               regWrEn,
  input  logic               regAddr,
  input  logic [7:0]         regWrData,
  output logic [7:0]         regRdData,
  input  logic [9:0]         periphEvt,
  input  logic               extPin,
  input  logic               xferAck,
  output logic               dmaReq
);
  trigStrobe_t       strobe;
  logic [CODE_W-1:0] selCode;
  logic              selBank;
  logic              causeFire;

  dma_trig_ctrl i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .causeFire (causeFire),
    .xferAck   (xferAck),
    .strobe    (strobe),
    .pending   (dmaReq)
  );

  dma_trig_datapath #(.SYNC_STAGES(2)) i_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .wrData    (regWrData),
    .periphEvt (periphEvt),
    .extPin    (extPin),
    .selCode   (selCode),
    .selBank   (selBank),
    .causeFire (causeFire)
  );

  always_comb begin
    if (!regAddr) regRdData = {1'b0, selBank, 2'b00, selCode};
    else          regRdData = {7'b0, dmaReq};
  end
endmodule

// File: rtl/dma_trig_checker.sv
module dma_trig_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       regWrEn,
  input logic       regAddr,
  input logic [7:0] regWrData,
  input logic [7:0] regRdData,
  input logic       xferAck,
  input logic       causeFire,
  input logic       dmaReq
);
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    causeFire |=> dmaReq);

  a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (xferAck && !causeFire) |=> !dmaReq);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (dmaReq && !xferAck && !(regWrEn && regAddr && !regWrData[0])) |=> dmaReq);

  a_r8_no_uncaused_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!dmaReq && !causeFire) |=> !dmaReq);

  a_r2_reserved_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !regAddr |-> (regRdData[5:4] == 2'b00 && !regRdData[7]));
endmodule

bind dma_trig_sel dma_trig_checker i_chk (.*);

// File: tb/test_dma_trig_sel.sv
module test_dma_trig_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regAddr = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic [9:0] periphEvt = '0;
  logic       extPin = 1'b1;
  logic       xferAck = 1'b0;
  logic       dmaReq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dma_trig_sel i_dma_trig_sel (.*);

  // {select value, event pulse, expected request}
  localparam int NV = 18;
  localparam logic [18:0] VEC [NV] = '{
    {8'h02, 10'b0000000001, 1'b1},  // R4
    {8'h02, 10'b0000000010, 1'b0},  // R4 unselected
    {8'h03, 10'b0000000010, 1'b1},  // R4
    {8'h04, 10'b0000000100, 1'b1},  // R4
    {8'h05, 10'b0000001000, 1'b1},  // R4
    {8'h0A, 10'b0000010000, 1'b1},  // R5
    {8'h0B, 10'b0000100000, 1'b1},  // R5
    {8'h0C, 10'b0001000000, 1'b1},  // R5
    {8'h0D, 10'b0010000000, 1'b1},  // R5
    {8'h0F, 10'b0100000000, 1'b1},  // R5
    {8'h0F, 10'b1011111111, 1'b0},  // R5 others masked
    {8'h45, 10'b1000000000, 1'b1},  // R7
    {8'h05, 10'b1000000000, 1'b0},  // R7 basic bank ignores it
    {8'h45, 10'b0000001000, 1'b0},  // R7 ext 0101 is not a timer
    {8'h06, 10'b1111111111, 1'b0},  // R8
    {8'h09, 10'b1111111111, 1'b0},  // R8
    {8'h0E, 10'b1111111111, 1'b0},  // R8
    {8'h4F, 10'b1111111111, 1'b0}   // R8
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 1'b0; regWrData = 8'h00;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    regAddr = a;
    #1 d = regRdData;
    regAddr = 1'b0;
  endtask

  task automatic pulse(input logic [9:0] ev);
    @(negedge clk); periphEvt = ev;
    @(negedge clk); periphEvt = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] r;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk({7'b0, dmaReq}, 8'h00, "R1 reset dmaReq");
    rd(1'b0, r); chk(r, 8'h00, "R1 reset select");

    for (int v = 0; v < NV; v++) begin
      wr(1'b0, VEC[v][18:11]);
      pulse(VEC[v][10:1]);
      chk({7'b0, dmaReq}, {7'b0, VEC[v][0]}, $sformatf("R4/R5/R7/R8 vector %0d", v));
      wr(1'b1, 8'h00);
    end

    // R2
    wr(1'b0, 8'hFF);
    rd(1'b0, r); chk(r, 8'h4F, "R2 reserved bits read 0");
    chk({7'b0, dmaReq}, 8'h00, "R3 swreq with bank=1");
    wr(1'b0, 8'h30);
    rd(1'b0, r); chk(r, 8'h00, "R2 bits 5..4 ignored");

    // R3
    wr(1'b0, 8'h81);
    chk({7'b0, dmaReq}, 8'h01, "R3 soft trigger");
    rd(1'b0, r); chk(r, 8'h01, "R3 swreq bit reads 0");
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h82);
    chk({7'b0, dmaReq}, 8'h00, "R3 wrong code");
    wr(1'b0, 8'hC1);
    chk({7'b0, dmaReq}, 8'h00, "R3 extended bank");
    wr(1'b0, 8'h01);
    chk({7'b0, dmaReq}, 8'h00, "R3 no swreq bit");

    // R9
    wr(1'b0, 8'h81);
    wr(1'b1, 8'h01);
    chk({7'b0, dmaReq}, 8'h01, "R9 write 1 keeps");
    idle(3);
    rd(1'b1, r); chk(r, 8'h01, "R9 sticky readback");
    wr(1'b1, 8'h00);
    chk({7'b0, dmaReq}, 8'h00, "R9 write 0 clears");
    rd(1'b1, r); chk(r, 8'h00, "R9 cleared readback");

    // R10
    wr(1'b0, 8'h81);
    @(negedge clk); xferAck = 1'b1;
    @(negedge clk); xferAck = 1'b0;
    chk({7'b0, dmaReq}, 8'h00, "R10 ack clears");
    wr(1'b0, 8'h02);
    @(negedge clk); xferAck = 1'b1; periphEvt = 10'b1;
    @(negedge clk); xferAck = 1'b0; periphEvt = '0;
    chk({7'b0, dmaReq}, 8'h01, "R10 set wins over ack");
    wr(1'b1, 8'h00);

    // R6
    wr(1'b0, 8'h00);
    @(negedge clk); extPin = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk({7'b0, dmaReq}, 8'h00, "R6 not before third edge");
    @(negedge clk);
    chk({7'b0, dmaReq}, 8'h01, "R6 falling edge request");
    wr(1'b1, 8'h00);
    idle(5);
    chk({7'b0, dmaReq}, 8'h00, "R6 one request per edge");
    @(negedge clk); extPin = 1'b1;
    idle(5);
    chk({7'b0, dmaReq}, 8'h00, "R6 rising edge ignored");

    // R11: pin high, switch around
    wr(1'b0, 8'h47);
    idle(4);
    wr(1'b0, 8'h00);
    idle(4);
    chk({7'b0, dmaReq}, 8'h00, "R11 switch with pin high");

    // R7 both edges
    wr(1'b0, 8'h47);
    @(negedge clk); extPin = 1'b0;
    idle(3);
    chk({7'b0, dmaReq}, 8'h01, "R7 falling edge any-edge mode");
    wr(1'b1, 8'h00);
    @(negedge clk); extPin = 1'b1;
    idle(2);
    chk({7'b0, dmaReq}, 8'h00, "R7 not before third edge");
    idle(1);
    chk({7'b0, dmaReq}, 8'h01, "R7 rising edge any-edge mode");
    wr(1'b1, 8'h00);

    // R11: pin low, switch codes
    @(negedge clk); extPin = 1'b0;
    idle(4);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h02);
    wr(1'b0, 8'h00);
    idle(4);
    chk({7'b0, dmaReq}, 8'h00, "R11 switch to pin code with pin low");
    wr(1'b0, 8'h47);
    idle(4);
    chk({7'b0, dmaReq}, 8'h00, "R11 switch to any-edge with pin low");
    @(negedge clk); extPin = 1'b1;
    idle(4);
    wr(1'b1, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule